// File: doc/BRIEF.md
# Radix-4 Online Digit-Serial Adder

This block adds two fractional operands that arrive one signed radix-4 digit per clock, most significant digit first. It returns the sum in the same redundant signed-digit form, also most significant digit first, one clock after each input digit. No carry ever ripples. Each position is settled from the position sum and a transfer digit taken from the next less significant position. The time per digit therefore does not depend on how many digits the operands have.

An operation opens with a digit flagged as the start and closes with a digit flagged as the last one. An n-digit operation yields n+1 result digits. The first is an integer-part digit, and the final one is a flush cycle that releases the held interim digit. A stop input ends the operation early, once the caller has the leading digits it needs, and suppresses every remaining digit cycle.

Top module: `online_add_r4`

## Requirements
- R1: Each digit, input or output, is a 3-bit two's complement code holding a value in -3..3. Inputs are taken most significant first, one digit of each operand per accepted cycle.
- R2: When a start digit is accepted, the next clock raises `out_valid` and `out_first`. The digit shown is the transfer of that position: +1 if x+y ≥ 3, -1 if x+y ≤ -3, 0 otherwise.
- R3: An n-digit operation (n ≥ 1, `in_last` on digit n) yields n+1 valid output digits. Output digit k appears one clock after input digit k+1 is accepted. The flush digit appears on the clock after the last input and carries `out_last`.
- R4: The output digits z0..zn satisfy Σ zk·4^-k = Σ (xj+yj)·4^-j exactly.
- R5: Every valid output digit lies in -3..3; the code 100 never appears.
- R6: A cycle with `stop` high consumes no input. `out_valid` is low on the next clock, and no flush digit follows. Further digits without `in_start` are ignored until a new start.
- R7: While idle, `in_valid` without `in_start` is ignored: `out_valid` stays low.
- R8: During the flush cycle the inputs are ignored. A start offered there is dropped, and the flush digit is unchanged.
- R9: A start digit accepted in the middle of an operation restarts it. The held interim digit is discarded, and the next output is a first digit formed as in R2.
- R10: Synchronous active-high reset clears the output flags and the held interim digit, and leaves the block idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input digit pair present |
| in_start | input | 1 | Digit pair is the most significant of an operation |
| in_last | input | 1 | Digit pair is the least significant of an operation |
| x_dig | input | 3 | Operand X digit, two's complement |
| y_dig | input | 3 | Operand Y digit, two's complement |
| stop | input | 1 | End the operation now |
| out_valid | output | 1 | Output digit present |
| out_first | output | 1 | Output digit is the integer-part digit |
| out_last | output | 1 | Output digit is the flush digit |
| out_dig | output | 3 | Sum digit, two's complement |

## Verification
The bench builds the block with its default radix exponent of 2, so digits are 3 bits and the digit set is -3..3. Operands of 1 to 16 digits then give exact values as 64-bit integers scaled by 4^n. Constant runs of +3 and -3 reach both transfer thresholds in every position and the extreme output digits. A start offered in the flush cycle, a restart mid-stream and stop requests made before and during the flush bring the sequencing corners within reach.

// File: rtl/oladd_pkg.sv
package oladd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FLUSH = 2'd2
  } seq_state_t;
endpackage

// File: rtl/oladd_split.sv
// Splits one position sum into a transfer digit and an interim digit.
module oladd_split #(
  parameter int LOG2_RADIX = 2
) (
  input  logic signed [LOG2_RADIX:0] x,
  input  logic signed [LOG2_RADIX:0] y,
  output logic signed [1:0]          t,
  output logic signed [LOG2_RADIX:0] w
);
  localparam int DW    = LOG2_RADIX + 1;
  localparam int PW    = LOG2_RADIX + 2;
  localparam int RADIX = 1 << LOG2_RADIX;
  localparam logic signed [PW-1:0] THR_P = PW'(RADIX - 1);
  localparam logic signed [PW-1:0] THR_N = -THR_P;
  localparam logic signed [PW-1:0] R_P   = PW'(RADIX);

  logic signed [PW-1:0] p;
  logic signed [PW-1:0] w_full;

  always_comb begin
    p = {x[DW-1], x} + {y[DW-1], y};
    if (p >= THR_P) begin
      t      = 2'sb01;
      w_full = p - R_P;
    end else if (p <= THR_N) begin
      t      = 2'sb11;
      w_full = p + R_P;
    end else begin
      t      = 2'sb00;
      w_full = p;
    end
    w = w_full[DW-1:0];
  end
endmodule

// File: rtl/oladd_merge.sv
// Forms the output digit from the held interim digit and the new transfer.
module oladd_merge #(
  parameter int LOG2_RADIX = 2
) (
  input  logic signed [LOG2_RADIX:0] w_prev,
  input  logic signed [1:0]          t,
  output logic signed [LOG2_RADIX:0] z
);
  localparam int DW = LOG2_RADIX + 1;
  always_comb z = w_prev + {{(DW-2){t[1]}}, t};
endmodule

// File: rtl/oladd_seq.sv
// Operation sequencing: idle, running, flush.
module oladd_seq
  import oladd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_start,
  input  logic in_last,
  input  logic stop,
  output logic accept,
  output logic flush_now
);
  seq_state_t state;

  always_comb begin
    accept    = in_valid && !stop && (state != ST_FLUSH) &&
                (in_start || (state == ST_RUN));
    flush_now = (state == ST_FLUSH) && !stop;
  end

  always_ff @(posedge clk) begin
    if (rst)                    state <= ST_IDLE;
    else if (stop)              state <= ST_IDLE;
    else if (state == ST_FLUSH) state <= ST_IDLE;
    else if (accept)            state <= in_last ? ST_FLUSH : ST_RUN;
  end
endmodule

// File: rtl/online_add_r4.sv
module online_add_r4 #(
  parameter int LOG2_RADIX = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic                  in_start,
  input  logic                  in_last,
  input  logic [LOG2_RADIX:0]   x_dig,
  input  logic [LOG2_RADIX:0]   y_dig,
  input  logic                  stop,
  output logic                  out_valid,
  output logic                  out_first,
  output logic                  out_last,
  output logic [LOG2_RADIX:0]   out_dig
);
  localparam int DW = LOG2_RADIX + 1;

  logic                 accept, flush_now;
  logic signed [1:0]    t_cur;
  logic signed [DW-1:0] w_cur, w_hold, w_sel, z_cur;

  oladd_seq u_seq (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_start(in_start),
    .in_last(in_last), .stop(stop), .accept(accept), .flush_now(flush_now)
  );

  oladd_split #(.LOG2_RADIX(LOG2_RADIX)) u_split (
    .x(x_dig), .y(y_dig), .t(t_cur), .w(w_cur)
  );

  always_comb w_sel = in_start ? '0 : w_hold;

  oladd_merge #(.LOG2_RADIX(LOG2_RADIX)) u_merge (
    .w_prev(w_sel), .t(t_cur), .z(z_cur)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_first <= 1'b0;
      out_last  <= 1'b0;
      out_dig   <= '0;
      w_hold    <= '0;
    end else begin
      out_valid <= accept || flush_now;
      out_first <= accept && in_start;
      out_last  <= flush_now;
      if (accept)         out_dig <= z_cur;
      else if (flush_now) out_dig <= w_hold;
      else                out_dig <= '0;
      if (accept)                 w_hold <= w_cur;
      else if (flush_now || stop) w_hold <= '0;
    end
  end
endmodule

// File: rtl/oladd_chk.sv
module oladd_chk #(
  parameter int DW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          stop,
  input logic          out_valid,
  input logic          out_first,
  input logic          out_last,
  input logic [DW-1:0] out_dig
);
  localparam logic [DW-1:0] BAD_CODE = {1'b1, {(DW-1){1'b0}}};

  // R10
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !out_valid);

  // R6
  stop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    stop |=> !out_valid);

  // R5
  digit_set_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_dig != BAD_CODE));

  // R3
  end_of_stream_chk: assert property (@(posedge clk) disable iff (rst)
    out_last |=> (!out_valid || out_first));

  // R7
  no_input_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid || out_last));

  // R3
  flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !(out_first && out_last));
endmodule

bind online_add_r4 oladd_chk #(.DW(LOG2_RADIX + 1)) u_oladd_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .stop(stop),
  .out_valid(out_valid), .out_first(out_first), .out_last(out_last),
  .out_dig(out_dig)
);

// File: tb/test_online_add_r4.sv
module test_online_add_r4;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_start = 1'b0, in_last = 1'b0, stop = 1'b0;
  logic [2:0] x_dig = '0, y_dig = '0;
  logic out_valid, out_first, out_last;
  logic [2:0] out_dig;

  int n_chk = 0;
  int n_bad = 0;
  int xa[16];
  int ya[16];
  int za[17];

  always #10 clk = ~clk;

  online_add_r4 i_online_add_r4 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_start(in_start),
    .in_last(in_last), .x_dig(x_dig), .y_dig(y_dig), .stop(stop),
    .out_valid(out_valid), .out_first(out_first), .out_last(out_last),
    .out_dig(out_dig)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int tr(input int p);
    if (p >= 3) return 1;
    if (p <= -3) return -1;
    return 0;
  endfunction

  function automatic int dv();
    return int'($signed(out_dig));
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idle_in();
    @(negedge clk);
    in_valid = 0; in_start = 0; in_last = 0; stop = 0;
  endtask

  // Runs an n-digit operation from xa/ya; poke drives a start during flush.
  task automatic do_op(input int n, input bit poke, input string tag);
    longint s = 0, zs = 0, w = 1;
    bit seq_ok = 1;
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      in_valid = 1; in_start = (j == 0); in_last = (j == n - 1); stop = 0;
      x_dig = 3'(xa[j]); y_dig = 3'(ya[j]);
      step();
      za[j] = dv();
      if (!(out_valid && (out_first == (j == 0)) && !out_last)) seq_ok = 0;
      if (j == 0)
        chk(dv() == tr(xa[0] + ya[0]), "R2 first digit", dv(), tr(xa[0] + ya[0]));
    end
    @(negedge clk);
    if (poke) begin
      in_valid = 1; in_start = 1; in_last = 0; x_dig = 3'd3; y_dig = 3'd3;
    end else begin
      in_valid = 0; in_start = 0; in_last = 0;
    end
    step();
    za[n] = dv();
    chk(seq_ok && out_valid && out_last, {"R3 stream flags ", tag}, out_last, 1);
    begin
      int wl = xa[n-1] + ya[n-1] - 4 * tr(xa[n-1] + ya[n-1]);
      chk(za[n] == wl, {"R8 flush digit ", tag}, za[n], wl);
    end
    for (int k = n; k >= 0; k--) begin
      zs += longint'(za[k]) * w;
      chk(za[k] >= -3 && za[k] <= 3, {"R5 digit range ", tag}, za[k], 0);
      if (k > 0) s += longint'(xa[k-1] + ya[k-1]) * w;
      w *= 4;
    end
    chk(zs == s, {"R4 value ", tag}, zs, s);
    idle_in();
    step();
    chk(!out_valid, {"R8 start in flush ignored ", tag}, out_valid, 0);
  endtask

  task automatic fill(input int n, input int mode);
    for (int j = 0; j < n; j++) begin
      case (mode)
        0: begin xa[j] = 3; ya[j] = 3; end
        1: begin xa[j] = -3; ya[j] = -3; end
        2: begin xa[j] = (j % 2) ? 3 : 1; ya[j] = (j % 2) ? -1 : 2; end
        default: begin
          xa[j] = int'($urandom_range(0, 6)) - 3;
          ya[j] = int'($urandom_range(0, 6)) - 3;
        end
      endcase
    end
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1; step(); step();
    chk(!out_valid && !out_first && !out_last, "R10 reset flags", out_valid, 0);
    @(negedge clk); rst = 0;
  endtask

  task automatic t_idle_ignore();
    @(negedge clk);
    in_valid = 1; in_start = 0; in_last = 0; x_dig = 3'd3; y_dig = 3'd3;
    step();
    chk(!out_valid, "R7 idle digit ignored", out_valid, 0);
    idle_in();
  endtask

  task automatic t_stop(input bit in_flush);
    fill(8, 3);
    for (int j = 0; j < (in_flush ? 2 : 3); j++) begin
      @(negedge clk);
      in_valid = 1; in_start = (j == 0); in_last = in_flush && (j == 1);
      x_dig = 3'(xa[j]); y_dig = 3'(ya[j]);
      step();
    end
    @(negedge clk);
    stop = 1; in_start = 0; in_last = 0; in_valid = 1;
    step();
    chk(!out_valid, in_flush ? "R6 stop suppresses flush" : "R6 stop ends output",
        out_valid, 0);
    @(negedge clk); stop = 0;
    step();
    chk(!out_valid, "R6 continuation after stop ignored", out_valid, 0);
    idle_in();
  endtask

  task automatic t_restart();
    fill(3, 0);
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      in_valid = 1; in_start = (j == 0); in_last = 0;
      x_dig = 3'(xa[j]); y_dig = 3'(ya[j]);
      step();
    end
    @(negedge clk);
    in_start = 1; x_dig = 3'd0; y_dig = 3'd1;
    step();
    chk(out_valid && out_first && dv() == 0, "R9 restart discards held digit", dv(), 0);
    idle_in();
    fill(5, 1);
    do_op(5, 0, "after restart");
  endtask

  initial begin
    repeat (3) step();
    chk(!out_valid, "R10 reset state", out_valid, 0);
    @(negedge clk); rst = 0;
    t_idle_ignore();
    fill(4, 0); do_op(4, 0, "all +3");
    chk(za[0] == 1 && za[1] == 3 && za[4] == 2, "R1 code +3 path", za[1], 3);
    fill(4, 1); do_op(4, 0, "all -3");
    chk(za[0] == -1 && za[1] == -3 && za[4] == -2, "R1 code -3 path", za[1], -3);
    fill(1, 2); do_op(1, 0, "single digit");
    fill(6, 2); do_op(6, 1, "flush poke");
    t_stop(0);
    t_stop(1);
    t_restart();
    for (int r = 0; r < 40; r++) begin
      int n = int'($urandom_range(4, 16));
      fill(n, 3);
      do_op(n, r % 3 == 0, "random");
    end
    t_reset();
    fill(5, 3); do_op(5, 0, "after reset");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule